// File: doc/BRIEF.md
# SPI Serial Clock Generator with Mode Control

The block turns the core clock into the serial clock of an SPI master and issues the two single-cycle strobes a shift register needs: one for driving the next output bit and one for sampling the incoming bit. A transfer engine holds `run` high for a whole number of bit periods. While `run` is high the block counts out bit periods, places the SCK edges according to the clock polarity and phase settings, and pulses the strobes on the matching edges. While `run` is low, SCK rests at its idle level.

The divide ratio comes from a 5-bit code with two ranges. Codes 16 to 31 give only even ratios, twice the value of the low four bits. Codes 0 to 15 divide by the code itself. Any ratio below 2 is run at 2. An odd ratio makes the high phase of SCK one core cycle longer than the low phase. A late-capture select delays the sample strobe by one core cycle. It is meant for the fastest ratios, where sampling right on the edge leaves too little margin. The code is taken when a transfer starts and is held until `run` falls.

SCK and both strobes are registered, so they all change on the same core clock edge. A strobe is high in the first cycle in which SCK shows its new level.

Top module: `spi_sck_gen`

## Requirements
- R1: While `run` is low, one cycle after each core clock edge, `sck` equals `cpol` and `shift_stb` is low. After reset, `sck`, `shift_stb` and `sample_stb` are all 0.
- R2: The SCK period in core cycles (the ratio) depends on `div_code`. For codes 16 to 31 the ratio is 2×(code−16). For codes 2 to 15 the ratio is the code. Codes 0, 1 and 16 give a ratio of 2. A transfer of N bits shows exactly 2N SCK transitions.
- R3: Within each bit period SCK is high for ceil(ratio/2) core cycles and low for floor(ratio/2) core cycles.
- R4: Counting the first cycle after `run` is sampled high as index 0, the first SCK edge away from idle (the leading edge) falls at index floor(ratio/2) when `cpol`=0 and at index ceil(ratio/2) when `cpol`=1. The trailing edge back to idle closes each bit period.
- R5: With `cpha`=0, `shift_stb` pulses at index 0, before any SCK edge, and with every trailing edge while `run` stays high. `sample_stb` pulses with every leading edge.
- R6: With `cpha`=1, `shift_stb` pulses with every leading edge. `sample_stb` pulses with every trailing edge, and this includes the return to idle when `run` falls at the end of the last bit.
- R7: With `late_capture`=1, every `sample_stb` pulse comes one core cycle later than with `late_capture`=0. The number of pulses does not change.
- R8: A change of `div_code` while `run` is high has no effect on the SCK period until the next transfer.
- R9: With `late_capture`=0, `shift_stb` and `sample_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 5 | Prescale code, two-range encoding (R2) |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | 0: sample on leading edge; 1: shift on leading edge |
| late_capture | input | 1 | Delay the sample strobe by one core cycle |
| run | input | 1 | Held high by the transfer engine for whole bit periods |
| sck | output | 1 | Serial clock pin |
| shift_stb | output | 1 | One-cycle pulse: drive the next output bit |
| sample_stb | output | 1 | One-cycle pulse: capture the input bit |

## Verification
The shift strobe and a delayed sample strobe can land in the same cycle. This happens when late capture is on and the delayed sample point reaches the next shift point. At ratio 2 in mode 0 it falls on every bit boundary except the last, and it also occurs at ratio 3 in the phase and polarity combinations that put the leading edge one cycle from a boundary. The bench provokes this with late capture at ratios 2 and 3 and both phase settings. Its reference model predicts both strobes high in those cycles and the bench counts the coincidences against the number each requirement gives. With late capture off, the bench checks that no such coincidence occurs in any transfer.

// File: rtl/spi_sck_gen.sv
module spi_sck_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] div_code,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       late_capture,
  input  logic       run,
  output logic       sck,
  output logic       shift_stb,
  output logic       sample_stb
);
  localparam int CW = 5;

  logic          active_q, lvl_q, samp_d_q, sck_q, shift_q, samp_q;
  logic [CW-1:0] cnt_q, per_q;
  logic [CW-1:0] code_ratio, per, lead, cnt_n;
  logic [CW:0]   hi_len;
  logic          lvl_n, lead_evt, trail_evt, start_evt, shift_evt, samp_evt;

  always_comb begin
    code_ratio = div_code[4] ? {div_code[3:0], 1'b0} : div_code;
    if (code_ratio < CW'(2)) code_ratio = CW'(2);
  end

  assign per    = active_q ? per_q : code_ratio;
  assign hi_len = ({1'b0, per} + (CW+1)'(1)) >> 1;
  assign lead   = cpol ? hi_len[CW-1:0] : (per >> 1);
  assign cnt_n  = (!active_q || cnt_q == per - CW'(1)) ? '0 : cnt_q + CW'(1);

  assign lvl_n     = run && (cnt_n >= lead);
  assign lead_evt  = run && (cnt_n == lead);
  assign trail_evt = lvl_q && !lvl_n;
  assign start_evt = run && (cnt_n == '0);
  assign shift_evt = cpha ? lead_evt : start_evt;
  assign samp_evt  = cpha ? trail_evt : lead_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      per_q    <= CW'(2);
      lvl_q    <= 1'b0;
      sck_q    <= 1'b0;
      shift_q  <= 1'b0;
      samp_d_q <= 1'b0;
      samp_q   <= 1'b0;
    end else begin
      active_q <= run;
      cnt_q    <= run ? cnt_n : '0;
      per_q    <= per;
      lvl_q    <= lvl_n;
      sck_q    <= cpol ^ lvl_n;
      shift_q  <= shift_evt;
      samp_d_q <= samp_evt;
      samp_q   <= late_capture ? samp_d_q : samp_evt;
    end
  end

  assign sck        = sck_q;
  assign shift_stb  = shift_q;
  assign sample_stb = samp_q;

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sck == $past(cpol)));

  p_no_shift_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !shift_stb);

  p_code_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && run) |=> (per_q == $past(per_q)));

  p_lead_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpha && $past(cpha) && shift_stb) |-> (sck != $past(sck)));

  p_strobe_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(late_capture)) |-> !(shift_stb && sample_stb));
endmodule

// File: tb/spi_sck_gen_tb.sv
module spi_sck_gen_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [4:0] code = 5'd2;
  logic       cpol = 1'b0, cpha = 1'b0, late = 1'b0, run = 1'b0;
  logic       sck, shs, sms;
  int         n_chk = 0, n_err = 0, cyc = 0;
  bit         cmp_on = 1'b0;

  always #4 clk = ~clk;

  spi_sck_gen u_dut (
    .clk(clk), .rst_n(rst_n), .div_code(code), .cpol(cpol), .cpha(cpha),
    .late_capture(late), .run(run), .sck(sck), .shift_stb(shs), .sample_stb(sms)
  );

  function automatic int ratio_of(int c);
    int r;
    r = (c < 16) ? c : 2 * (c - 16);
    if (r < 2) r = 2;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: time since start, position by modulo
  bit m_act, m_lvl, m_prev_se, e_sck, e_sh, e_sm;
  int m_t, m_per;
  always @(posedge clk) begin
    int p, t, pos, ld;
    bit lvl, le, bs, te, se;
    if (!rst_n) begin
      m_act = 0; m_lvl = 0; m_prev_se = 0; m_t = 0; m_per = 2;
      e_sck = 0; e_sh = 0; e_sm = 0;
    end else begin
      lvl = 0; le = 0; bs = 0;
      if (run) begin
        p   = m_act ? m_per : ratio_of(int'(code));
        t   = m_act ? m_t + 1 : 0;
        pos = t % p;
        ld  = cpol ? (p + 1) / 2 : p / 2;
        lvl = (pos >= ld);
        le  = (pos == ld);
        bs  = (pos == 0);
        m_per = p; m_t = t;
      end
      te = m_lvl && !lvl;
      se = cpha ? te : le;
      e_sck = cpol ^ lvl;
      e_sh  = cpha ? le : bs;
      e_sm  = late ? m_prev_se : se;
      m_prev_se = se;
      m_lvl = lvl;
      m_act = run;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(sck === e_sck, "R4", "sck vs model", int'(sck), int'(e_sck));
      chk(shs === e_sh, "R5", "shift_stb vs model", int'(shs), int'(e_sh));
      chk(sms === e_sm, "R6", "sample_stb vs model", int'(sms), int'(e_sm));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  bit rs[256], rsh[256], rsm[256];

  task automatic do_xfer(int c, bit pl, bit ph, bit lt, int nb, int newc);
    int p, k, hi, ld, edges, nsh, nsm, fle, sle, hcnt, both, fsm, eboth;
    bit prev;
    p = ratio_of(c); k = nb * p + 2; hi = (p + 1) / 2;
    ld = pl ? hi : p / 2;
    edges = 0; nsh = 0; nsm = 0; fle = -1; sle = -1; hcnt = 0; both = 0; fsm = -1;
    @(negedge clk);
    code = 5'(c); cpol = pl; cpha = ph; late = lt;
    repeat (2) @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      rs[i] = sck; rsh[i] = shs; rsm[i] = sms;
      if (i == 1 && newc >= 0) code = 5'(newc);
      if (i == nb * p - 1) run = 1'b0;
    end
    repeat (3) @(negedge clk);
    prev = pl;
    for (int i = 0; i < k; i++) begin
      if (rs[i] != prev) begin
        edges++;
        if (rs[i] != pl) begin
          if (fle < 0) fle = i; else if (sle < 0) sle = i;
        end
      end
      prev = rs[i];
      if (i < p && rs[i]) hcnt++;
      if (rsh[i]) nsh++;
      if (rsm[i]) begin nsm++; if (fsm < 0) fsm = i; end
      if (rsh[i] && rsm[i]) both++;
    end
    chk(edges == 2 * nb, "R2", $sformatf("edges code %0d", c), edges, 2 * nb);
    if (nb >= 2) chk(sle - fle == p, "R2", $sformatf("period code %0d", c), sle - fle, p);
    chk(hcnt == hi, "R3", $sformatf("high time code %0d", c), hcnt, hi);
    chk(fle == ld, "R4", "first leading edge", fle, ld);
    chk(nsh == nb, ph ? "R6" : "R5", "shift count", nsh, nb);
    chk(nsm == nb, ph ? "R6" : "R5", "sample count", nsm, nb);
    if (!ph) chk(rsh[0] == 1'b1, "R5", "shift before first edge", int'(rsh[0]), 1);
    chk(fsm == (ph ? p : ld) + int'(lt), "R7", "first sample index", fsm, (ph ? p : ld) + int'(lt));
    eboth = (lt && (ph ? (ld == 1) : (ld + 1 == p))) ? nb - 1 : 0;
    chk(both == eboth, "R9", "shift/sample coincidences", both, eboth);
    chk(sck == pl, "R1", "idle level after transfer", int'(sck), int'(pl));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sck == 1'b0 && shs == 1'b0 && sms == 1'b0, "R1", "reset outputs",
        int'({sck, shs, sms}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck == 1'b1, "R1", "idle high", int'(sck), 1);
    chk(shs == 1'b0 && sms == 1'b0, "R1", "no strobes idle", int'({shs, sms}), 0);
    do_xfer(0, 0, 0, 0, 3, -1);
    do_xfer(16, 1, 0, 0, 3, -1);
    do_xfer(1, 0, 1, 0, 3, -1);
    do_xfer(2, 0, 0, 1, 4, -1);
    do_xfer(3, 0, 0, 0, 3, -1);
    do_xfer(3, 1, 1, 0, 3, -1);
    do_xfer(3, 0, 1, 1, 3, -1);
    do_xfer(5, 1, 0, 1, 3, -1);
    do_xfer(15, 0, 1, 1, 2, -1);
    do_xfer(17, 0, 0, 0, 3, -1);
    do_xfer(18, 1, 1, 0, 3, -1);
    do_xfer(23, 0, 1, 0, 2, -1);
    do_xfer(31, 1, 0, 0, 2, -1);
    // R8: code switched to 10 mid-transfer, period must stay 4
    do_xfer(4, 0, 0, 0, 3, 10);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule